// File: doc/BRIEF.md
# Write Protection Boundary Controller

This block keeps the write-protection state of a small serial memory: an 8-bit boundary address, a protection flag and a one-time lock bit. The instruction decoder in front of it reports each decoded instruction as a single-cycle strobe (`cmdValid`) with a kind code on `cmdKind`: 0 any other instruction, 1 protect-enable, 2 protect-clear, 3 protect-write, 4 protect-disable, 5 protect-read. The block also sees the protect pin, the write pin and the write-enable latch. From this it decides whether a protect command may change the state and start a programming cycle.

The block answers two questions at the same time for the array write path. It says whether a single address is protected. It also says whether a page of four words is protected, where the page shares the upper address bits of `chkAddr`. For a protect-read, the shifter steps `rdIdx` from 0 to 9 and takes one bit per index from `rdBit`.

Top module: `wprot_ctrl`

## Requirements
- R1: While `porN` is low at a clock edge, the next state is boundary 0xFF, flag 1, lock 0, no authorisation and `progStart` 0.
- R2: `addrBlocked` is 1 exactly when the flag is 0 and `chkAddr` is greater than or equal to the boundary.
- R3: `pageBlocked` is 1 exactly when the flag is 0 and the highest page address is greater than or equal to the boundary. The highest page address is `chkAddr` with its two low bits forced to 1.
- R4: A protect-write (kind 3) is granted when three conditions hold: the previous instruction was an accepted protect-enable, both pins are high, and the lock is 0. A granted protect-write loads `cmdAddr` into the boundary and clears the flag to 0. `progStart` is then high for exactly the following cycle.
- R5: A granted protect-clear (kind 2) loads 0xFF and sets the flag to 1, with the same `progStart` pulse.
- R6: A protect-enable (kind 1) is accepted only when `wel`, `protPin` and `wrPin` are all high. It never changes the boundary, the flag or `progStart`.
- R7: The authorisation is lost in three cases: any other instruction arrives, including a protect-enable that is not accepted; a protect command arrives with either pin low; or a protect command arrives that was not directly preceded by an accepted protect-enable. A protect command in any of these cases changes nothing and gives no `progStart`.
- R8: A granted protect-disable (kind 4) sets `locked`. Once `locked` is set, the boundary and the flag stay unchanged and `progStart` stays 0 until `porN` is asserted.
- R9: While `protPin` is high, `rdBit` gives 0 for index 0. For indices 1 to 8 it gives the boundary bits, most significant first. For index 9 it gives the flag, and for any other index it gives 0. While `protPin` is low, `rdBit` is 0.
- R10: `rstN` low clears only the authorisation and `progStart`. The boundary, the flag and the lock keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous functional reset, active low |
| porN | input | 1 | Synchronous power-on/test initialisation, active low |
| cmdValid | input | 1 | One decoded instruction this cycle |
| cmdKind | input | 3 | Instruction kind code |
| cmdAddr | input | 8 | Address field of the instruction |
| protPin | input | 1 | Protect-enable pin level |
| wrPin | input | 1 | Write-enable pin level |
| wel | input | 1 | Write-enable latch state |
| chkAddr | input | 8 | Address under protection check |
| addrBlocked | output | 1 | Single address is protected |
| pageBlocked | output | 1 | Some word of the four-word page is protected |
| rdIdx | input | 4 | Protect-read bit index |
| rdBit | output | 1 | Protect-read output bit |
| progStart | output | 1 | Protect command starts a programming cycle |
| protBound | output | 8 | Boundary register |
| protFlag | output | 1 | Flag (0 = protection active) |
| locked | output | 1 | One-time lock bit |

## Verification
Three events can fall in the same cycle: a granted protect-write or protect-clear updates the boundary, while the protection checks and the read path are sampling that boundary. The bench moves `chkAddr` and `rdIdx` on every cycle, including the cycles where a grant lands. A behavioural model then judges `addrBlocked`, `pageBlocked` and `rdBit` against the boundary value that holds in the cycle after the edge. Protect-disable also raises `locked` in the same cycle as its own `progStart` pulse. The bench checks that this one pulse is allowed and that later grants give no pulse.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    CMD_OTHER = 3'd0,
    CMD_PEN   = 3'd1,
    CMD_PCLR  = 3'd2,
    CMD_PWR   = 3'd3,
    CMD_PDIS  = 3'd4,
    CMD_PRD   = 3'd5
  } cmdKind_e;

  typedef struct packed {
    logic ldBound;
    logic ldClear;
    logic setLock;
  } strobes_t;
endpackage

// File: rtl/wprot_ctl.sv
module wprot_ctl
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       porN,
  input  logic       cmdValid,
  input  logic [2:0] cmdKind,
  input  logic       protPin,
  input  logic       wrPin,
  input  logic       wel,
  input  logic       locked,
  output strobes_t   stb,
  output logic       progStart
);
  logic armed;
  logic pinsOk;
  logic isProt;
  logic grant;

  assign pinsOk = protPin && wrPin;
  assign isProt = (cmdKind == CMD_PCLR) || (cmdKind == CMD_PWR) || (cmdKind == CMD_PDIS);
  assign grant  = cmdValid && isProt && armed && pinsOk && !locked;

  always_comb begin
    stb.ldBound = grant && (cmdKind == CMD_PWR);
    stb.ldClear = grant && (cmdKind == CMD_PCLR);
    stb.setLock = grant && (cmdKind == CMD_PDIS);
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      armed     <= 1'b0;
      progStart <= 1'b0;
    end else begin
      progStart <= grant;
      if (cmdValid) armed <= (cmdKind == CMD_PEN) && wel && pinsOk;
    end
  end
endmodule

// File: rtl/wprot_dp.sv
module wprot_dp
  import wprot_pkg::*;
#(
  parameter int AW  = 8,
  parameter int PW  = 2,
  parameter int RIW = 4
) (
  input  logic           clk,
  input  logic           porN,
  input  strobes_t       stb,
  input  logic [AW-1:0]  cmdAddr,
  input  logic [AW-1:0]  chkAddr,
  input  logic [RIW-1:0] rdIdx,
  input  logic           protPin,
  output logic           addrBlocked,
  output logic           pageBlocked,
  output logic           rdBit,
  output logic [AW-1:0]  protBound,
  output logic           protFlag,
  output logic           locked
);
  localparam int LAST_IDX = AW + 1;

  logic [AW-1:0] pageTop;
  logic [LAST_IDX:0] rdVec;

  always_ff @(posedge clk) begin
    if (!porN) begin
      protBound <= '1;
      protFlag  <= 1'b1;
      locked    <= 1'b0;
    end else begin
      if (stb.ldBound) begin
        protBound <= cmdAddr;
        protFlag  <= 1'b0;
      end else if (stb.ldClear) begin
        protBound <= '1;
        protFlag  <= 1'b1;
      end
      if (stb.setLock) locked <= 1'b1;
    end
  end

  assign pageTop     = {chkAddr[AW-1:PW], {PW{1'b1}}};
  assign addrBlocked = !protFlag && (chkAddr >= protBound);
  assign pageBlocked = !protFlag && (pageTop >= protBound);

  // bit i of rdVec is what index i shows
  generate
    for (genvar i = 1; i <= AW; i++) begin : g_rd
      assign rdVec[i] = protBound[AW - i];
    end
  endgenerate
  assign rdVec[0]        = 1'b0;
  assign rdVec[LAST_IDX] = protFlag;

  always_comb begin
    rdBit = 1'b0;
    if (protPin && (int'(rdIdx) <= LAST_IDX)) rdBit = rdVec[rdIdx];
  end
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
  import wprot_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 2,
  localparam int RIW = $clog2(AW + 2)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           porN,
  input  logic           cmdValid,
  input  logic [2:0]     cmdKind,
  input  logic [AW-1:0]  cmdAddr,
  input  logic           protPin,
  input  logic           wrPin,
  input  logic           wel,
  input  logic [AW-1:0]  chkAddr,
  output logic           addrBlocked,
  output logic           pageBlocked,
  input  logic [RIW-1:0] rdIdx,
  output logic           rdBit,
  output logic           progStart,
  output logic [AW-1:0]  protBound,
  output logic           protFlag,
  output logic           locked
);
  strobes_t stb;

  wprot_ctl u_ctl (
    .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .protPin(protPin), .wrPin(wrPin), .wel(wel), .locked(locked),
    .stb(stb), .progStart(progStart)
  );

  wprot_dp #(.AW(AW), .PW(PW), .RIW(RIW)) u_dp (
    .clk(clk), .porN(porN), .stb(stb), .cmdAddr(cmdAddr), .chkAddr(chkAddr),
    .rdIdx(rdIdx), .protPin(protPin), .addrBlocked(addrBlocked),
    .pageBlocked(pageBlocked), .rdBit(rdBit), .protBound(protBound),
    .protFlag(protFlag), .locked(locked)
  );
endmodule

// File: rtl/wprot_chk.sv
module wprot_chk #(parameter int AW = 8) (
  input logic          clk,
  input logic          rstN,
  input logic          porN,
  input logic          cmdValid,
  input logic [2:0]    cmdKind,
  input logic          addrBlocked,
  input logic          pageBlocked,
  input logic          progStart,
  input logic [AW-1:0] protBound,
  input logic          protFlag,
  input logic          locked
);
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!porN) locked |=> locked);
  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!porN)
    locked |=> ($stable(protBound) && $stable(protFlag)));
  // R4
  prog_cause_chk: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (cmdValid && cmdKind == 3'd0) |=> !progStart);
  // R3
  page_cover_chk: assert property (@(posedge clk) disable iff (!porN)
    addrBlocked |-> pageBlocked);
  // R2
  flag_open_chk: assert property (@(posedge clk) disable iff (!porN)
    protFlag |-> (!addrBlocked && !pageBlocked));
endmodule

bind wprot_ctrl wprot_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdKind(cmdKind),
  .addrBlocked(addrBlocked), .pageBlocked(pageBlocked), .progStart(progStart),
  .protBound(protBound), .protFlag(protFlag), .locked(locked)
);

// File: tb/wprot_ctrl_tb.sv
module wprot_ctrl_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0, porN = 1'b0, cmdValid = 1'b0;
  logic [2:0] cmdKind = 3'd0;
  logic [7:0] cmdAddr = 8'd0, chkAddr = 8'd0;
  logic protPin = 1'b0, wrPin = 1'b0, wel = 1'b0;
  logic [3:0] rdIdx = 4'd0;
  logic addrBlocked, pageBlocked, rdBit, progStart, protFlag, locked;
  logic [7:0] protBound;
  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  int mBound = 255, mFlag = 1, mLock = 0, mArmed = 0, mProg = 0;

  always #4 clk = ~clk;

  wprot_ctrl u_dut (
    .clk(clk), .rstN(rstN), .porN(porN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .protPin(protPin), .wrPin(wrPin), .wel(wel), .chkAddr(chkAddr),
    .addrBlocked(addrBlocked), .pageBlocked(pageBlocked), .rdIdx(rdIdx), .rdBit(rdBit),
    .progStart(progStart), .protBound(protBound), .protFlag(protFlag), .locked(locked)
  );

  always @(posedge clk) begin
    int ok;
    cyc = cyc + 1;
    if (!porN) begin
      mBound = 255; mFlag = 1; mLock = 0; mArmed = 0; mProg = 0;
    end else if (!rstN) begin
      mArmed = 0; mProg = 0;
    end else begin
      mProg = 0;
      if (cmdValid) begin
        ok = (mArmed == 1 && protPin && wrPin && mLock == 0) ? 1 : 0;
        mArmed = 0;
        case (cmdKind)
          3'd1: mArmed = (wel && protPin && wrPin) ? 1 : 0;
          3'd2: if (ok == 1) begin mBound = 255; mFlag = 1; mProg = 1; end
          3'd3: if (ok == 1) begin mBound = int'(cmdAddr); mFlag = 0; mProg = 1; end
          3'd4: if (ok == 1) begin mLock = 1; mProg = 1; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int a, expRd, top;
    a = int'(chkAddr);
    top = a | 3;
    chk("R4/R5 progStart", int'(progStart), mProg);
    chk("R1/R10 protBound", int'(protBound), mBound);
    chk("R1/R10 protFlag", int'(protFlag), mFlag);
    chk("R8 locked", int'(locked), mLock);
    chk("R2 addrBlocked", int'(addrBlocked), (mFlag == 0 && a >= mBound) ? 1 : 0);
    chk("R3 pageBlocked", int'(pageBlocked), (mFlag == 0 && top >= mBound) ? 1 : 0);
    expRd = 0;
    if (protPin) begin
      if (rdIdx >= 1 && rdIdx <= 8) expRd = (mBound >> (8 - int'(rdIdx))) & 1;
      else if (rdIdx == 9) expRd = mFlag;
    end
    chk("R9 rdBit", int'(rdBit), expRd);
  endtask

  // one cycle: present inputs, wait an edge, compare at the falling edge
  task automatic step(input logic v, input logic [2:0] k, input logic [7:0] ad);
    cmdValid = v; cmdKind = k; cmdAddr = ad;
    chkAddr = chkAddr + 8'd29;
    rdIdx = (rdIdx == 4'd10) ? 4'd0 : rdIdx + 4'd1;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 8'd0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 3'd0, 8'd0);          // R1 initial state under porN
    porN = 1'b1; rstN = 1'b1;
    protPin = 1'b1; wrPin = 1'b1; wel = 1'b1;
    idle(12);                        // R9 read sequence of cleared register
    // R4 grant protect-write
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd3, 8'h42);
    idle(24);                        // R2/R3 sweep
    chkAddr = 8'h40; step(1'b0, 3'd0, 8'h00);
    chk("R3 page 0x5D..", int'(pageBlocked), 1);
    // R6 enable without wel rejected
    wel = 1'b0; step(1'b1, 3'd1, 8'h00); wel = 1'b1;
    step(1'b1, 3'd3, 8'h10); idle(2);
    chk("R6 bound kept", int'(protBound), 8'h42);
    // R7 other instruction between cancels
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd0, 8'h00); step(1'b1, 3'd3, 8'h20);
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd5, 8'h00); step(1'b1, 3'd2, 8'hFF);
    // R7 pin low at command
    step(1'b1, 3'd1, 8'h00); wrPin = 1'b0; step(1'b1, 3'd3, 8'h30); wrPin = 1'b1; idle(1);
    chk("R7 bound kept", int'(protBound), 8'h42);
    // R10 rstN keeps state, drops authorisation
    step(1'b1, 3'd1, 8'h00); rstN = 1'b0; step(1'b0, 3'd0, 8'h00); rstN = 1'b1;
    step(1'b1, 3'd3, 8'h05); idle(2);
    chk("R10 flag kept", int'(protFlag), 0);
    // R5 clear
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd2, 8'h00); idle(12);
    chk("R5 flag set", int'(protFlag), 1);
    // R4 boundary 0 covers all, then R9 with protPin low
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd3, 8'h00);
    protPin = 1'b0; idle(11); protPin = 1'b1;
    // R4 boundary near top
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd3, 8'hFD); idle(20);
    // R8 lock, then attempts are ignored
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd4, 8'h00); idle(1);
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd2, 8'h00); idle(1);
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd3, 8'h11); idle(1);
    chk("R8 locked bound", int'(protBound), 8'hFD);
    rstN = 1'b0; idle(2); rstN = 1'b1; idle(1);
    chk("R10 lock survives", int'(locked), 1);
    // R1 power-on initialisation clears lock
    porN = 1'b0; idle(1); porN = 1'b1; idle(2);
    chk("R1 lock cleared", int'(locked), 0);
    step(1'b1, 3'd1, 8'h00); step(1'b1, 3'd3, 8'h80); idle(12);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule